// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter Bank

This block decides whether a finished CAN frame is kept by either of two receive buffers. When a frame ends, the receiver pulses a strobe and presents the frame's identifier, its extended-format flag (IDE) and its remote-request flag (RTR). The block captures them. In the next cycle it reports, for each buffer, whether the frame is accepted. For an accepted frame it also reports which filter caused the acceptance and whether the frame was a remote request.

Buffer A has the higher priority. It owns one mask and two filters. Buffer B owns one mask and four filters. Each buffer has a two-bit receive mode. The mode either leaves the choice of frame format to each filter, restricts the buffer to one format, or accepts every frame without filtering. Masks, filters and modes sit in plain registers loaded through a write-only port.

Top module: `can_accept_bank`

## Requirements
- R1: A mask bit of 0 makes the matching identifier bit a don't-care. A mask bit of 1 requires the frame bit to equal the filter bit.
- R2: A standard frame carries its 11-bit identifier in `frame_id_i[28:18]` and is compared only on those bits; the low 18 bits are ignored. An extended frame is compared on all 29 bits.
- R3: In mode 00, a filter can hit only when its extended-enable bit equals the frame's IDE flag.
- R4: Mode 01 accepts only standard frames (IDE=0) and mode 10 accepts only extended frames (IDE=1). A filter whose extended-enable bit disagrees with the mode never hits.
- R5: Mode 11 accepts every frame. The reported index is the lowest filter that matches under the mode-00 rule, or 7 when no filter matches.
- R6: Filters 0 and 1 belong to buffer A and filters 2 to 5 belong to buffer B. When several filters of a buffer match, the lowest number is reported.
- R7: Each info output places RTR in bit 3 and the filter index in bits 2:0. The field is 0 when its buffer has no hit.
- R8: `result_valid_o` is high for exactly one cycle, in the cycle after `frame_done_i`. Hit and info keep the result of the last captured frame until the next strobe.
- R9: Register addresses are as follows. Address 0 holds mask A and address 1 holds mask B, each in bits 28:0. Addresses 2 to 7 hold filters 0 to 5, with the identifier in bits 28:0 and the extended-enable bit in bit 29. Address 8 holds the modes: buffer A in bits 1:0 and buffer B in bits 3:2. Reset clears every register.
- R10: While reset is asserted, and after reset until the first strobe, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 30 | Register write data |
| frame_done_i | input | 1 | One-cycle strobe: frame complete |
| frame_id_i | input | 29 | Frame identifier |
| frame_ide_i | input | 1 | 1 = extended frame |
| frame_rtr_i | input | 1 | 1 = remote request |
| result_valid_o | output | 1 | Result pulse, one cycle after the strobe |
| hit_a_o | output | 1 | Buffer A accepts the frame |
| info_a_o | output | 4 | Buffer A: {RTR, filter index} |
| hit_b_o | output | 1 | Buffer B accepts the frame |
| info_b_o | output | 4 | Buffer B: {RTR, filter index} |

## Verification
The bench programs a fixed set of masks and filters and drives a table of frames through it, covering six cases:
- Two frames that match in both buffers and differ only in RTR, which exposes the flag's bit position.
- An extended frame whose top bits equal a standard-only filter, which separates the IDE rule from the identifier compare.
- A frame that differs from a filter only in a bit that buffer A masks out, which shows the don't-care behaviour.
- An extended frame that differs from a filter only in a bit that buffer B's full mask covers, which shows the exact-equality behaviour.
- Standard frames with junk in the low bits, which confirm that only 11 bits are compared.
- A frame hitting two filters at once, which exposes the priority order.

Directed passes then switch each buffer through the format-restricted and bypass modes. They also check that the valid pulse lasts one cycle and that reset restores the cleared register defaults.

// File: rtl/can_accept_pkg.sv
package can_accept_pkg;
  localparam int ID_W  = 29;  // extended identifier width
  localparam int STD_W = 11;  // standard identifier width, top bits of ID_W
  localparam int IDX_W = 3;   // filter index width; all-ones means no filter
  localparam int INFO_W = IDX_W + 1;

  typedef enum logic [1:0] {
    MODE_FILTER = 2'b00,
    MODE_STD    = 2'b01,
    MODE_EXT    = 2'b10,
    MODE_ALL    = 2'b11
  } rx_mode_e;

  typedef struct packed {
    logic             rtr;
    logic [IDX_W-1:0] idx;
  } acc_info_t;
endpackage

// File: rtl/can_accept_regs.sv
module can_accept_regs
  import can_accept_pkg::*;
#(
  parameter int N_FLT_A = 2,
  parameter int N_FLT_B = 4,
  parameter int ADDR_W  = 4,
  localparam int N_TOT  = N_FLT_A + N_FLT_B,
  localparam int DATA_W = ID_W + 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  output logic [ID_W-1:0]            mask_a_o,
  output logic [ID_W-1:0]            mask_b_o,
  output logic [N_TOT-1:0][ID_W-1:0] flt_id_o,
  output logic [N_TOT-1:0]           flt_ext_o,
  output rx_mode_e                   mode_a_o,
  output rx_mode_e                   mode_b_o
);
  localparam int MASK_A_ADDR = 0;
  localparam int MASK_B_ADDR = 1;
  localparam int FLT_BASE    = 2;
  localparam int MODE_ADDR   = FLT_BASE + N_TOT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_a_o <= '0;
      mask_b_o <= '0;
      mode_a_o <= MODE_FILTER;
      mode_b_o <= MODE_FILTER;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_W'(MASK_A_ADDR)) mask_a_o <= wr_data_i[ID_W-1:0];
      if (wr_addr_i == ADDR_W'(MASK_B_ADDR)) mask_b_o <= wr_data_i[ID_W-1:0];
      if (wr_addr_i == ADDR_W'(MODE_ADDR)) begin
        mode_a_o <= rx_mode_e'(wr_data_i[1:0]);
        mode_b_o <= rx_mode_e'(wr_data_i[3:2]);
      end
    end
  end

  for (genvar k = 0; k < N_TOT; k++) begin : g_flt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flt_id_o[k]  <= '0;
        flt_ext_o[k] <= 1'b0;
      end else if (wr_en_i && wr_addr_i == ADDR_W'(FLT_BASE + k)) begin
        flt_id_o[k]  <= wr_data_i[ID_W-1:0];
        flt_ext_o[k] <= wr_data_i[ID_W];
      end
    end
  end
endmodule

// File: rtl/can_filter_match.sv
module can_filter_match
  import can_accept_pkg::*;
(
  input  logic [ID_W-1:0] frm_id_i,
  input  logic            frm_ide_i,
  input  logic [ID_W-1:0] mask_i,
  input  logic [ID_W-1:0] flt_id_i,
  input  logic            flt_ext_i,
  output logic            match_o
);
  logic [ID_W-1:0] diff;
  logic            std_ok, ext_ok;

  always_comb begin
    diff    = (frm_id_i ^ flt_id_i) & mask_i;
    std_ok  = ~|diff[ID_W-1 -: STD_W];
    ext_ok  = ~|diff;
    match_o = (flt_ext_i == frm_ide_i) && (frm_ide_i ? ext_ok : std_ok);
  end
endmodule

// File: rtl/can_accept_buf.sv
module can_accept_buf
  import can_accept_pkg::*;
#(
  parameter int N_FLT = 2,
  parameter int BASE  = 0
) (
  input  logic                       en_i,
  input  logic [ID_W-1:0]            frm_id_i,
  input  logic                       frm_ide_i,
  input  logic                       frm_rtr_i,
  input  logic [ID_W-1:0]            mask_i,
  input  logic [N_FLT-1:0][ID_W-1:0] flt_id_i,
  input  logic [N_FLT-1:0]           flt_ext_i,
  input  rx_mode_e                   mode_i,
  output logic                       hit_o,
  output logic [INFO_W-1:0]          info_o
);
  logic [N_FLT-1:0] match;
  logic [IDX_W-1:0] first_idx;
  logic             found, accept;
  acc_info_t        info;

  for (genvar i = 0; i < N_FLT; i++) begin : g_match
    can_filter_match u_match (
      .frm_id_i  (frm_id_i),
      .frm_ide_i (frm_ide_i),
      .mask_i    (mask_i),
      .flt_id_i  (flt_id_i[i]),
      .flt_ext_i (flt_ext_i[i]),
      .match_o   (match[i])
    );
  end

  // lowest filter number wins
  always_comb begin
    first_idx = '1;
    for (int i = N_FLT - 1; i >= 0; i--) begin
      if (match[i]) first_idx = IDX_W'(BASE + i);
    end
    found = |match;
  end

  always_comb begin
    unique case (mode_i)
      MODE_FILTER: accept = found;
      MODE_STD:    accept = found & ~frm_ide_i;
      MODE_EXT:    accept = found & frm_ide_i;
      MODE_ALL:    accept = 1'b1;
      default:     accept = 1'b0;
    endcase
    hit_o    = en_i & accept;
    info.rtr = frm_rtr_i;
    info.idx = found ? first_idx : '1;
    info_o   = hit_o ? info : '0;
  end
endmodule

// File: rtl/can_accept_bank.sv
module can_accept_bank
  import can_accept_pkg::*;
#(
  parameter int N_FLT_A = 2,
  parameter int N_FLT_B = 4,
  parameter int ADDR_W  = 4,
  localparam int N_TOT  = N_FLT_A + N_FLT_B,
  localparam int DATA_W = ID_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              frame_done_i,
  input  logic [ID_W-1:0]   frame_id_i,
  input  logic              frame_ide_i,
  input  logic              frame_rtr_i,
  output logic              result_valid_o,
  output logic              hit_a_o,
  output logic [INFO_W-1:0] info_a_o,
  output logic              hit_b_o,
  output logic [INFO_W-1:0] info_b_o
);
  logic [ID_W-1:0]            mask_a, mask_b;
  logic [N_TOT-1:0][ID_W-1:0] flt_id;
  logic [N_TOT-1:0]           flt_ext;
  rx_mode_e                   mode_a, mode_b;

  logic [ID_W-1:0] frm_id_q;
  logic            frm_ide_q, frm_rtr_q, seen_q, valid_q;

  can_accept_regs #(
    .N_FLT_A (N_FLT_A),
    .N_FLT_B (N_FLT_B),
    .ADDR_W  (ADDR_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .mask_a_o  (mask_a),
    .mask_b_o  (mask_b),
    .flt_id_o  (flt_id),
    .flt_ext_o (flt_ext),
    .mode_a_o  (mode_a),
    .mode_b_o  (mode_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frm_id_q  <= '0;
      frm_ide_q <= 1'b0;
      frm_rtr_q <= 1'b0;
      seen_q    <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      valid_q <= frame_done_i;
      if (frame_done_i) begin
        frm_id_q  <= frame_id_i;
        frm_ide_q <= frame_ide_i;
        frm_rtr_q <= frame_rtr_i;
        seen_q    <= 1'b1;
      end
    end
  end

  can_accept_buf #(.N_FLT(N_FLT_A), .BASE(0)) u_buf_a (
    .en_i      (seen_q),
    .frm_id_i  (frm_id_q),
    .frm_ide_i (frm_ide_q),
    .frm_rtr_i (frm_rtr_q),
    .mask_i    (mask_a),
    .flt_id_i  (flt_id[N_FLT_A-1:0]),
    .flt_ext_i (flt_ext[N_FLT_A-1:0]),
    .mode_i    (mode_a),
    .hit_o     (hit_a_o),
    .info_o    (info_a_o)
  );

  can_accept_buf #(.N_FLT(N_FLT_B), .BASE(N_FLT_A)) u_buf_b (
    .en_i      (seen_q),
    .frm_id_i  (frm_id_q),
    .frm_ide_i (frm_ide_q),
    .frm_rtr_i (frm_rtr_q),
    .mask_i    (mask_b),
    .flt_id_i  (flt_id[N_TOT-1:N_FLT_A]),
    .flt_ext_i (flt_ext[N_TOT-1:N_FLT_A]),
    .mode_i    (mode_b),
    .hit_o     (hit_b_o),
    .info_o    (info_b_o)
  );

  assign result_valid_o = valid_q;
endmodule

// File: rtl/can_accept_chk.sv
module can_accept_chk #(
  parameter int N_FLT_A = 2,
  parameter int N_FLT_B = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_done_i,
  input logic       frame_ide_i,
  input logic       frame_rtr_i,
  input logic       result_valid_o,
  input logic       hit_a_o,
  input logic [3:0] info_a_o,
  input logic       hit_b_o,
  input logic [3:0] info_b_o,
  input logic [1:0] mode_a,
  input logic [1:0] mode_b
);
  a_r8_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (result_valid_o == $past(frame_done_i)));

  a_r7_info_zero_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_a_o |-> (info_a_o == 4'h0));
  a_r7_info_zero_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_b_o |-> (info_b_o == 4'h0));

  a_r7_rtr_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && hit_a_o) |-> (info_a_o[3] == $past(frame_rtr_i)));
  a_r7_rtr_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && hit_b_o) |-> (info_b_o[3] == $past(frame_rtr_i)));

  a_r5_bypass_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && mode_a == 2'b11) |-> hit_a_o);
  a_r5_bypass_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && mode_b == 2'b11) |-> hit_b_o);

  a_r4_std_only_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && hit_a_o && mode_a == 2'b01) |-> !$past(frame_ide_i));
  a_r4_ext_only_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && hit_a_o && mode_a == 2'b10) |-> $past(frame_ide_i));
  a_r4_std_only_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && hit_b_o && mode_b == 2'b01) |-> !$past(frame_ide_i));
  a_r4_ext_only_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && hit_b_o && mode_b == 2'b10) |-> $past(frame_ide_i));

  a_r6_range_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_a_o |-> (32'(info_a_o[2:0]) < N_FLT_A || info_a_o[2:0] == 3'h7));
  a_r6_range_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_b_o |-> ((32'(info_b_o[2:0]) >= N_FLT_A &&
                  32'(info_b_o[2:0]) < N_FLT_A + N_FLT_B) || info_b_o[2:0] == 3'h7));
endmodule

bind can_accept_bank can_accept_chk #(.N_FLT_A(N_FLT_A), .N_FLT_B(N_FLT_B)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .frame_done_i   (frame_done_i),
  .frame_ide_i    (frame_ide_i),
  .frame_rtr_i    (frame_rtr_i),
  .result_valid_o (result_valid_o),
  .hit_a_o        (hit_a_o),
  .info_a_o       (info_a_o),
  .hit_b_o        (hit_b_o),
  .info_b_o       (info_b_o),
  .mode_a         (mode_a),
  .mode_b         (mode_b)
);

// File: tb/can_accept_bank_tb_top.sv
module can_accept_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [29:0] wr_data = '0;
  logic        done = 1'b0;
  logic [28:0] fid = '0;
  logic        fide = 1'b0;
  logic        frtr = 1'b0;
  logic        vld, hit_a, hit_b;
  logic [3:0]  info_a, info_b;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  can_accept_bank dut_i (
    .clk_i (clk), .rst_ni (rst_n),
    .wr_en_i (wr_en), .wr_addr_i (wr_addr), .wr_data_i (wr_data),
    .frame_done_i (done), .frame_id_i (fid), .frame_ide_i (fide), .frame_rtr_i (frtr),
    .result_valid_o (vld), .hit_a_o (hit_a), .info_a_o (info_a),
    .hit_b_o (hit_b), .info_b_o (info_b)
  );

  // {id[28:0], ide, rtr, hit_a, info_a[3:0], hit_b, info_b[3:0]}
  localparam logic [40:0] VEC [9] = '{
    {11'h123, 18'h0,     1'b0, 1'b0, 1'b1, 4'h0, 1'b1, 4'h2},
    {11'h123, 18'h0,     1'b0, 1'b1, 1'b1, 4'h8, 1'b1, 4'hA},
    {11'h123, 18'h55,    1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 4'h0},
    {11'h456, 18'h3FFFF, 1'b1, 1'b0, 1'b1, 4'h1, 1'b0, 4'h0},
    {29'h1234567,        1'b1, 1'b1, 1'b0, 4'h0, 1'b1, 4'hB},
    {11'h7FF, 18'h0,     1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 4'h5},
    {11'h7FF, 18'h3FFFF, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 4'h5},
    {29'h1234566,        1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 4'h0},
    {11'h456, 18'h0,     1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 4'h0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [29:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // returns at the negedge after the capture edge: result visible
  task automatic send(input logic [28:0] id, input logic ide, input logic rtr);
    @(negedge clk); done = 1'b1; fid = id; fide = ide; frtr = rtr;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic expect_res(input string tag, input logic ha, input logic [3:0] ia,
                            input logic hb, input logic [3:0] ib);
    check({tag, " hit_a"}, 32'(hit_a), 32'(ha));
    check({tag, " info_a"}, 32'(info_a), 32'(ia));
    check({tag, " hit_b"}, 32'(hit_b), 32'(hb));
    check({tag, " info_b"}, 32'(info_b), 32'(ib));
  endtask

  task automatic program_cfg();
    wr(4'd0, {1'b0, 11'h7FF, 18'h0});      // mask A: top 11 bits only
    wr(4'd1, {1'b0, 29'h1FFFFFFF});        // mask B: all bits
    wr(4'd2, {1'b0, 11'h123, 18'h0});      // F0 std
    wr(4'd3, {1'b1, 11'h456, 18'h0});      // F1 ext
    wr(4'd4, {1'b0, 11'h123, 18'h0});      // F2 std
    wr(4'd5, {1'b1, 29'h1234567});         // F3 ext
    wr(4'd6, {1'b1, 29'h1234567});         // F4 ext, duplicate of F3
    wr(4'd7, {1'b0, 11'h7FF, 18'h0});      // F5 std
    wr(4'd8, 30'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    #5;
    // R10: reset state
    check("R10 valid in reset", 32'(vld), 0);
    expect_res("R10 reset", 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_res("R10 before first frame", 0, 0, 0, 0);

    // R9 defaults: zero masks, std-format zero filters
    send({11'h3AB, 18'h0}, 1'b0, 1'b0);
    expect_res("R9 defaults std", 1, 4'h0, 1, 4'h2);
    send(29'h0ABCDEF, 1'b1, 1'b0);
    expect_res("R9 defaults ext", 0, 0, 0, 0);

    program_cfg();

    // vector table: R1 R2 R3 R6 R7
    for (int v = 0; v < 9; v++) begin
      send(VEC[v][40:12], VEC[v][11], VEC[v][10]);
      check($sformatf("R8 valid vec%0d", v), 32'(vld), 1);
      expect_res($sformatf("R1/R2/R3/R6/R7 vec%0d", v),
                 VEC[v][9], VEC[v][8:5], VEC[v][4], VEC[v][3:0]);
    end

    // R8: pulse lasts one cycle, result held
    @(negedge clk);
    check("R8 valid drops", 32'(vld), 0);
    check("R8 result held", 32'(hit_a), 0);

    // R4: mode 01 on buffer A
    wr(4'd8, {26'h0, 2'b00, 2'b01});
    send({11'h123, 18'h0}, 1'b0, 1'b0);
    expect_res("R4 std-only std frame", 1, 4'h0, 1, 4'h2);
    send({11'h456, 18'h3FFFF}, 1'b1, 1'b0);
    check("R4 std-only rejects ext", 32'(hit_a), 0);

    // R4: mode 10 on buffer A
    wr(4'd8, {26'h0, 2'b00, 2'b10});
    send({11'h456, 18'h3FFFF}, 1'b1, 1'b1);
    check("R4 ext-only ext frame", 32'(info_a), 32'h9);
    check("R4 ext-only hit", 32'(hit_a), 1);
    send({11'h123, 18'h0}, 1'b0, 1'b0);
    check("R4 ext-only rejects std", 32'(hit_a), 0);
    check("R4 buffer B unaffected", 32'(info_b), 32'h2);

    // R5: mode 11 on buffer B
    wr(4'd8, {26'h0, 2'b11, 2'b00});
    send(29'h0000001, 1'b1, 1'b1);
    expect_res("R5 bypass no filter", 0, 0, 1, 4'hF);
    send({11'h7FF, 18'h0}, 1'b0, 1'b0);
    expect_res("R5 bypass std match", 0, 0, 1, 4'h5);
    send(29'h1234567, 1'b1, 1'b0);
    expect_res("R5 R6 bypass lowest", 0, 0, 1, 4'h3);

    // R10 / R9: reset mid-run clears outputs and registers
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R10 valid under reset", 32'(vld), 0);
    expect_res("R10 under reset", 0, 0, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    send(29'h1234567, 1'b1, 1'b0);
    expect_res("R9 cleared after reset", 0, 0, 0, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule